// File: doc/BRIEF.md
# Weighted 4x4 Coefficient Quantizer and Rescaler

This block turns a stream of 4x4 transform coefficients into quantized levels, or turns quantized levels back into reconstructed coefficients. Every position in the block has its own weight taken from an intra or an inter weighting matrix. Coefficients arrive one per valid cycle in raster order: index k = 4*row + col, with row = k/4 and col = k%4. The quantizer parameter, the intra/inter select and the direction select are sampled together with the first coefficient of each block. They hold for all sixteen positions of that block.

The multiplier used at a position depends on QP mod 6 and on the position class. The even class has row and col both even, the odd class has both odd, and the mixed class covers every other position. The weighting matrix changes that multiplier. In the forward direction the quantizer multiplier is divided by the weight. In the inverse direction the rescale factor is multiplied by the weight. Both products are precomputed into constant tables, so the datapath needs no divider.

A small controller tracks block position with two states. ST_IDLE waits for the first coefficient of a block; a valid input there latches the block settings and moves to ST_BLOCK at position 1. ST_BLOCK advances the position on each valid input and returns to ST_IDLE after the coefficient at position 15. Idle cycles are allowed anywhere. Results leave a three-stage pipeline with a valid flag.

Top module: `wquant4x4`

## Requirements
- R1: Forward (in_inverse=0): out = sign(c) * ((|c| * LS) >> (15 + floor(Q/6))), with LS = floor(MF*16/W) and Q the effective QP; the magnitude of -32768 is 32768.
- R2: MF by QP mod 6 = 0..5 is: even class 13107,11916,10082,9362,8192,7282; odd class 5243,4660,4194,3647,3355,2893; mixed class 8066,7490,6554,5825,5243,4559. V is: even 10,11,13,14,16,18; odd 16,18,20,23,25,29; mixed 13,14,16,18,20,23.
- R3: in_intra=1 selects the intra weights, by row: 0 12 19 26 / 12 19 26 31 / 19 26 31 35 / 26 31 35 39. in_intra=0 selects the inter weights: 0 13 18 21 / 13 18 21 24 / 18 21 24 27 / 21 24 27 30.
- R4: A weight of 0 acts as 16, so the DC position uses an unweighted factor in both directions.
- R5: Inverse (in_inverse=1) with floor(Q/6) >= 4: out = (c * V * W) << (floor(Q/6) - 4).
- R6: Inverse with floor(Q/6) < 4: out = (c*V*W + 2^(s-1)) >>> s, with s = 4 - floor(Q/6) and an arithmetic (floor) shift.
- R7: Results saturate to the signed 16-bit range [-32768, 32767].
- R8: Each valid input produces exactly one output, with out_valid high exactly 3 clock cycles later and in input order.
- R9: in_qp, in_intra and in_inverse are sampled only with the first coefficient of a block; changes on later coefficients of the same block have no effect.
- R10: A block is 16 valid coefficients. Idle cycles inside a block do not advance the position, and the 17th valid coefficient starts a new block.
- R11: An in_qp above 51 is treated as 51.
- R12: Reset drives out_valid low and returns the position to the start of a block, so a partial block in progress is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A coefficient is present this cycle |
| in_coef | input | 16 | Signed coefficient or level |
| in_qp | input | 6 | Quantizer parameter, sampled at block start |
| in_intra | input | 1 | 1 = intra weights, 0 = inter weights |
| in_inverse | input | 1 | 1 = rescale (inverse), 0 = quantize (forward) |
| out_valid | output | 1 | out_coef holds a result |
| out_coef | output | 16 | Signed result, saturated |

## Verification
Two cases are hard to reach from the ports. The first is proving that settings are ignored after the first coefficient. The stimulus flips QP, the matrix select and even the direction on every later coefficient of a block, and the scoreboard still expects the first coefficient's settings. The second is a reset that lands in the middle of a partly delivered block, which can leave the hidden position counter off the block start. After five coefficients and a reset, a full block with new settings follows. Its outputs only match if the position restarted at zero. Idle gaps inside a block and back-to-back blocks probe the boundary counting. Extreme levels at QP 51 drive the inverse saturation, and QP 0 to 23 exercise the rounding right shift.

// File: rtl/wq_pkg.sv
package wq_pkg;

    localparam int DIM     = 4;
    localparam int POS_N   = DIM * DIM;
    localparam int POS_W   = $clog2(POS_N);
    localparam int QP_W    = 6;
    localparam int QP_MAX  = 51;
    localparam int QDIV_W  = 4;
    localparam int QMOD_W  = 3;
    localparam int NMOD    = 6;
    localparam int FAC_W   = 16;
    localparam int UNIT_W  = 16;
    localparam int FWD_SH  = 15;
    localparam int INV_REF = 4;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BLOCK = 1'b1
    } wq_state_e;

    typedef struct packed {
        logic [QP_W-1:0] qp;
        logic            intra;
        logic            inv;
    } wq_cfg_t;

    // 0: row and col even, 1: both odd, 2: mixed
    function automatic int pos_class(input int pos);
        int r;
        int c;
        r = pos / DIM;
        c = pos % DIM;
        if ((r % 2 == 0) && (c % 2 == 0)) return 0;
        if ((r % 2 == 1) && (c % 2 == 1)) return 1;
        return 2;
    endfunction

    function automatic int mf_of(input int cls, input int m);
        int key;
        key = cls * 8 + m;
        case (key)
            0:  return 13107;
            1:  return 11916;
            2:  return 10082;
            3:  return 9362;
            4:  return 8192;
            5:  return 7282;
            8:  return 5243;
            9:  return 4660;
            10: return 4194;
            11: return 3647;
            12: return 3355;
            13: return 2893;
            16: return 8066;
            17: return 7490;
            18: return 6554;
            19: return 5825;
            20: return 5243;
            21: return 4559;
            default: return 0;
        endcase
    endfunction

    function automatic int v_of(input int cls, input int m);
        int key;
        key = cls * 8 + m;
        case (key)
            0:  return 10;
            1:  return 11;
            2:  return 13;
            3:  return 14;
            4:  return 16;
            5:  return 18;
            8:  return 16;
            9:  return 18;
            10: return 20;
            11: return 23;
            12: return 25;
            13: return 29;
            16: return 13;
            17: return 14;
            18: return 16;
            19: return 18;
            20: return 20;
            21: return 23;
            default: return 0;
        endcase
    endfunction

    // Both matrices are constant along anti-diagonals (row + col).
    function automatic int weight_of(input int intra, input int pos);
        int d;
        d = pos / DIM + pos % DIM;
        if (intra != 0) begin
            case (d)
                0: return 0;
                1: return 12;
                2: return 19;
                3: return 26;
                4: return 31;
                5: return 35;
                default: return 39;
            endcase
        end
        case (d)
            0: return 0;
            1: return 13;
            2: return 18;
            3: return 21;
            4: return 24;
            5: return 27;
            default: return 30;
        endcase
    endfunction

    function automatic int eff_weight(input int intra, input int pos);
        int w;
        w = weight_of(intra, pos);
        return (w == 0) ? UNIT_W : w;
    endfunction

    function automatic logic [FAC_W-1:0] fwd_factor(input int intra, input int pos, input int m);
        return FAC_W'((mf_of(pos_class(pos), m) * UNIT_W) / eff_weight(intra, pos));
    endfunction

    function automatic logic [FAC_W-1:0] inv_factor(input int intra, input int pos, input int m);
        return FAC_W'(v_of(pos_class(pos), m) * eff_weight(intra, pos));
    endfunction

endpackage

// File: rtl/wq_seq.sv
module wq_seq
    import wq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  wq_cfg_t          live_cfg,
    output logic             fire,
    output logic [POS_W-1:0] cur_pos,
    output wq_cfg_t          cur_cfg
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(POS_N - 1);

    wq_state_e        state_q, state_d;
    logic [POS_W-1:0] pos_q, pos_d;
    wq_cfg_t          cfg_q, cfg_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            cfg_q   <= cfg_d;
        end
    end

    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        cfg_d   = cfg_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    cfg_d   = live_cfg;
                    pos_d   = POS_W'(1);
                    state_d = ST_BLOCK;
                end
            end
            ST_BLOCK: begin
                if (in_valid) begin
                    if (pos_q == LAST_POS) begin
                        pos_d   = '0;
                        state_d = ST_IDLE;
                    end else begin
                        pos_d = pos_q + POS_W'(1);
                    end
                end
            end
        endcase
    end

    always_comb begin
        fire    = in_valid;
        cur_pos = pos_q;
        unique case (state_q)
            ST_IDLE:  cur_cfg = live_cfg;
            ST_BLOCK: cur_cfg = cfg_q;
        endcase
    end

    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLOCK) |=> $stable(cfg_q));

    p_block_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLOCK && in_valid && pos_q == LAST_POS) |=> (state_q == ST_IDLE && pos_q == '0));

    p_pos_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLOCK && in_valid && pos_q != LAST_POS) |=> (pos_q == $past(pos_q) + POS_W'(1)));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid) |=> $stable(pos_q));

endmodule

// File: rtl/wq_factor.sv
module wq_factor
    import wq_pkg::*;
#(
    parameter int COEF_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fire,
    input  logic [POS_W-1:0]         pos,
    input  wq_cfg_t                  cfg,
    input  logic signed [COEF_W-1:0] coef,
    output logic                     s1_valid,
    output logic signed [COEF_W-1:0] s1_coef,
    output logic [FAC_W-1:0]         s1_fac,
    output logic [QDIV_W-1:0]        s1_qdiv,
    output logic                     s1_inv
);

    logic [FAC_W-1:0] fwd_rom [2][POS_N][NMOD];
    logic [FAC_W-1:0] inv_rom [2][POS_N][NMOD];

    for (genvar gi = 0; gi < 2; gi++) begin : g_sel
        for (genvar gp = 0; gp < POS_N; gp++) begin : g_pos
            for (genvar gm = 0; gm < NMOD; gm++) begin : g_mod
                assign fwd_rom[gi][gp][gm] = fwd_factor(gi, gp, gm);
                assign inv_rom[gi][gp][gm] = inv_factor(gi, gp, gm);
            end
        end
    end

    logic [QP_W-1:0]   qp_c;
    logic [QDIV_W-1:0] qdiv;
    logic [QMOD_W-1:0] qmod;
    logic [FAC_W-1:0]  fac;

    always_comb begin
        qp_c = (cfg.qp > QP_W'(QP_MAX)) ? QP_W'(QP_MAX) : cfg.qp;
        qdiv = QDIV_W'(qp_c / QP_W'(NMOD));
        qmod = QMOD_W'(qp_c % QP_W'(NMOD));
        fac  = cfg.inv ? inv_rom[cfg.intra][pos][qmod] : fwd_rom[cfg.intra][pos][qmod];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_coef  <= '0;
            s1_fac   <= '0;
            s1_qdiv  <= '0;
            s1_inv   <= 1'b0;
        end else begin
            s1_valid <= fire;
            if (fire) begin
                s1_coef <= coef;
                s1_fac  <= fac;
                s1_qdiv <= qdiv;
                s1_inv  <= cfg.inv;
            end
        end
    end

    p_qp_clamp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> (s1_qdiv <= QDIV_W'(QP_MAX / NMOD)));

    p_fac_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> (s1_fac != '0));

endmodule

// File: rtl/wq_scale.sv
module wq_scale
    import wq_pkg::*;
#(
    parameter int COEF_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     s1_valid,
    input  logic signed [COEF_W-1:0] s1_coef,
    input  logic [FAC_W-1:0]         s1_fac,
    input  logic [QDIV_W-1:0]        s1_qdiv,
    input  logic                     s1_inv,
    output logic                     out_valid,
    output logic signed [COEF_W-1:0] out_coef
);

    localparam int PROD_W = COEF_W + FAC_W + 2;
    localparam int SH_W   = 5;
    localparam int RS_W   = 3;
    localparam logic signed [PROD_W-1:0] SAT_HI = PROD_W'((longint'(1) <<< (COEF_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] SAT_LO = -SAT_HI - PROD_W'(1);

    // stage 2: multiply
    logic signed [COEF_W:0]   coef_x;
    logic [COEF_W:0]          mag;
    logic signed [PROD_W-1:0] a_op, b_op, prod;

    always_comb begin
        coef_x = {s1_coef[COEF_W-1], s1_coef};
        mag    = coef_x[COEF_W] ? (COEF_W+1)'(-coef_x) : coef_x;
        a_op   = s1_inv ? {{(PROD_W-COEF_W-1){coef_x[COEF_W]}}, coef_x}
                        : {{(PROD_W-COEF_W-1){1'b0}}, mag};
        b_op   = {{(PROD_W-FAC_W){1'b0}}, s1_fac};
        prod   = a_op * b_op;
    end

    logic                     s2_valid, s2_neg, s2_inv;
    logic signed [PROD_W-1:0] s2_prod;
    logic [QDIV_W-1:0]        s2_qdiv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_neg   <= 1'b0;
            s2_inv   <= 1'b0;
            s2_prod  <= '0;
            s2_qdiv  <= '0;
        end else begin
            s2_valid <= s1_valid;
            if (s1_valid) begin
                s2_neg  <= s1_coef[COEF_W-1];
                s2_inv  <= s1_inv;
                s2_prod <= prod;
                s2_qdiv <= s1_qdiv;
            end
        end
    end

    // stage 3: shift, round, restore sign, saturate
    logic [SH_W-1:0]          fsh;
    logic [RS_W-1:0]          rsh;
    logic signed [PROD_W-1:0] fmag, rnd, res;
    logic signed [COEF_W-1:0] sat_v;

    always_comb begin
        fsh  = SH_W'(FWD_SH) + SH_W'(s2_qdiv);
        fmag = s2_prod >>> fsh;
        rsh  = '0;
        rnd  = '0;
        if (!s2_inv) begin
            res = s2_neg ? -fmag : fmag;
        end else if (s2_qdiv >= QDIV_W'(INV_REF)) begin
            res = s2_prod <<< (s2_qdiv - QDIV_W'(INV_REF));
        end else begin
            rsh = RS_W'(QDIV_W'(INV_REF) - s2_qdiv);
            rnd = PROD_W'(1) <<< (rsh - RS_W'(1));
            res = (s2_prod + rnd) >>> rsh;
        end
        if (res > SAT_HI)      sat_v = SAT_HI[COEF_W-1:0];
        else if (res < SAT_LO) sat_v = SAT_LO[COEF_W-1:0];
        else                   sat_v = res[COEF_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_coef  <= '0;
        end else begin
            out_valid <= s2_valid;
            if (s2_valid) out_coef <= sat_v;
        end
    end

    p_fwd_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid && !s2_inv && s2_neg) |=> (out_coef <= 0));

    p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid && s2_inv && !s2_neg) |=> (out_coef >= 0));

    p_neg_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid && s2_neg) |=> (out_coef <= 0));

endmodule

// File: rtl/wquant4x4.sv
module wquant4x4
    import wq_pkg::*;
#(
    parameter int COEF_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [COEF_W-1:0] in_coef,
    input  logic [QP_W-1:0]          in_qp,
    input  logic                     in_intra,
    input  logic                     in_inverse,
    output logic                     out_valid,
    output logic signed [COEF_W-1:0] out_coef
);

    wq_cfg_t                  live_cfg, cur_cfg;
    logic                     fire;
    logic [POS_W-1:0]         cur_pos;
    logic                     s1_valid, s1_inv;
    logic signed [COEF_W-1:0] s1_coef;
    logic [FAC_W-1:0]         s1_fac;
    logic [QDIV_W-1:0]        s1_qdiv;

    assign live_cfg = '{qp: in_qp, intra: in_intra, inv: in_inverse};

    wq_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .live_cfg (live_cfg),
        .fire     (fire),
        .cur_pos  (cur_pos),
        .cur_cfg  (cur_cfg)
    );

    wq_factor #(.COEF_W(COEF_W)) u_factor (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .pos      (cur_pos),
        .cfg      (cur_cfg),
        .coef     (in_coef),
        .s1_valid (s1_valid),
        .s1_coef  (s1_coef),
        .s1_fac   (s1_fac),
        .s1_qdiv  (s1_qdiv),
        .s1_inv   (s1_inv)
    );

    wq_scale #(.COEF_W(COEF_W)) u_scale (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .s1_coef   (s1_coef),
        .s1_fac    (s1_fac),
        .s1_qdiv   (s1_qdiv),
        .s1_inv    (s1_inv),
        .out_valid (out_valid),
        .out_coef  (out_coef)
    );

    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 3));

endmodule

// File: tb/wquant4x4_bench.sv
`timescale 1ns/1ps
module wquant4x4_bench;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_coef = '0;
    logic [5:0]         in_qp = '0;
    logic               in_intra = 1'b0;
    logic               in_inverse = 1'b0;
    logic               out_valid;
    logic signed [15:0] out_coef;

    always #2.5 clk = ~clk;

    wquant4x4 u_wquant4x4 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_coef(in_coef),
        .in_qp(in_qp), .in_intra(in_intra), .in_inverse(in_inverse),
        .out_valid(out_valid), .out_coef(out_coef)
    );

    typedef struct {
        int     val;
        longint due;
        string  tag;
    } exp_t;

    exp_t   sb[$];
    longint cyc = 0;
    int     n_chk = 0;
    int     n_fail = 0;
    bit     done = 1'b0;

    int MF_T [3][6] = '{'{13107,11916,10082,9362,8192,7282},
                        '{5243,4660,4194,3647,3355,2893},
                        '{8066,7490,6554,5825,5243,4559}};
    int V_T  [3][6] = '{'{10,11,13,14,16,18},
                        '{16,18,20,23,25,29},
                        '{13,14,16,18,20,23}};
    int W_A  [16] = '{0,12,19,26, 12,19,26,31, 19,26,31,35, 26,31,35,39};
    int W_E  [16] = '{0,13,18,21, 13,18,21,24, 18,21,24,27, 21,24,27,30};

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int model(int c, int qp, bit intra, bit inv, int k);
        int q, d, m, r, co, cls, w;
        longint x, ls;
        q  = (qp > 51) ? 51 : qp;
        d  = q / 6;
        m  = q % 6;
        r  = k / 4;
        co = k % 4;
        if (r % 2 == 0 && co % 2 == 0)      cls = 0;
        else if (r % 2 == 1 && co % 2 == 1) cls = 1;
        else                                cls = 2;
        w = intra ? W_A[k] : W_E[k];
        if (w == 0) w = 16;
        if (!inv) begin
            ls = longint'(MF_T[cls][m]) * 16 / w;
            x  = (c < 0) ? -longint'(c) : longint'(c);
            x  = (x * ls) >> (15 + d);
            if (c < 0) x = -x;
        end else begin
            x = longint'(c) * V_T[cls][m] * w;
            if (d >= 4) x = x <<< (d - 4);
            else        x = (x + (longint'(1) <<< (3 - d))) >>> (4 - d);
        end
        if (x > 32767)  x = 32767;
        if (x < -32768) x = -32768;
        return int'(x);
    endfunction

    function automatic int pat(int blk, int k);
        if (k == 0) return (blk % 2 == 0) ? 32767 : -32768;
        if (k == 3) return -1;
        if (k == 4) return 1;
        if (k == 6) return 0;
        if (k == 5) return (blk % 2 == 0) ? -32768 : 32767;
        return (((blk * 7 + k * 13) * 2971 + blk * k * 113) % 65536) - 32768;
    endfunction

    task automatic send_coefs(int qp, bit intra, bit inv, int blk, int count,
                              bit chg, bit gap, string tag);
        for (int k = 0; k < count; k++) begin
            if (gap && (k == 9 || k == 10)) begin
                @(negedge clk);
                in_valid   = 1'b0;
                in_coef    = 16'sh1234;
                in_qp      = 6'd7;
                in_inverse = ~inv;
            end
            @(negedge clk);
            in_valid   = 1'b1;
            in_coef    = 16'(pat(blk, k));
            in_qp      = (chg && k > 0) ? 6'(qp ^ 42) : 6'(qp);
            in_intra   = (chg && k > 0) ? ~intra : intra;
            in_inverse = (chg && k > 0) ? ~inv : inv;
            sb.push_back('{model(pat(blk, k), qp, intra, inv, k), cyc + 3, tag});
        end
    endtask

    task automatic go_idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                n_chk++;
                if (sb.size() == 0) begin
                    n_fail++;
                    $display("FAIL R8: unexpected output actual=%0d expected=none", out_coef);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (e.due != cyc) begin
                        n_fail++;
                        $display("FAIL R8: output cycle actual=%0d expected=%0d", cyc, e.due);
                    end else if (int'(out_coef) != e.val) begin
                        n_fail++;
                        $display("FAIL %s: value actual=%0d expected=%0d", e.tag, out_coef, e.val);
                    end
                end
            end else if (sb.size() > 0 && sb[0].due <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                n_chk++;
                n_fail++;
                $display("FAIL R8: missing output actual=none expected=%0d at cycle %0d", e.val, e.due);
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        // R12: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            n_chk++;
            if (out_valid !== 1'b0) begin
                n_fail++;
                $display("FAIL R12: out_valid in reset actual=%0b expected=0", out_valid);
            end
        end
        @(negedge clk);
        rst_n = 1'b1;

        send_coefs(28, 1'b1, 1'b0, 0, 16, 1'b0, 1'b0, "R1 R2 R3");
        send_coefs(0,  1'b0, 1'b0, 1, 16, 1'b0, 1'b0, "R1 R3 R4");
        send_coefs(10, 1'b0, 1'b1, 2, 16, 1'b0, 1'b0, "R6 R2");
        send_coefs(3,  1'b1, 1'b1, 3, 16, 1'b0, 1'b0, "R6 R4");
        send_coefs(51, 1'b1, 1'b1, 4, 16, 1'b0, 1'b0, "R5 R7");
        go_idle(2);
        send_coefs(30, 1'b1, 1'b1, 5, 16, 1'b1, 1'b1, "R9 R10 R5");
        send_coefs(17, 1'b0, 1'b0, 6, 16, 1'b1, 1'b0, "R9 R10 R1");
        send_coefs(63, 1'b0, 1'b0, 7, 16, 1'b0, 1'b0, "R11");
        send_coefs(60, 1'b1, 1'b1, 8, 16, 1'b0, 1'b0, "R11 R7");
        send_coefs(44, 1'b0, 1'b1, 9, 16, 1'b0, 1'b1, "R10 R5");
        go_idle(6);

        // R12: partial block, then reset mid-block
        send_coefs(20, 1'b0, 1'b0, 10, 5, 1'b0, 1'b0, "R1");
        go_idle(6);
        rst_n = 1'b0;
        go_idle(2);
        @(negedge clk);
        rst_n = 1'b1;
        send_coefs(8, 1'b1, 1'b1, 11, 16, 1'b0, 1'b0, "R12 R10 R6");
        send_coefs(38, 1'b1, 1'b0, 12, 16, 1'b0, 1'b0, "R12 R1");
        go_idle(10);

        n_chk++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R8: pending outputs actual=%0d expected=0", sb.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule